// File: doc/BRIEF.md
# Sector Write-Protection Controller

This block keeps the write-protection state of a flash-style array split into eight equal 64 KB sectors. It runs on the system clock. The write, chip and output strobes arrive already synchronized, and three digital flags stand in for the high-voltage qualifiers on the address-9, output-enable and chip-enable pins. On a falling write strobe the block decides whether a protect or unprotect pulse is armed. It then times how long the strobe stays low and commits the change on the rising strobe, but only if the pulse was long enough.

Protection is granted one sector at a time: the sector is named by address bits 18:16. Protection is withdrawn from all sectors together, and only once every sector is already protected. A verify read returns a byte that shows the state of the addressed sector. The 8-bit protection state also drives a per-sector inhibit to the program/erase path, which turns a request for a protected sector into a blocked one in the same cycle.

Top module: `sector_wp_ctrl`

## Requirements
- R1: After reset, `inhibit` is 00h, `busy`, `op_done`, `pulse_error`, `unprot_reject` and `rd_valid` are low, and `rd_data` is 00h.
- R2: A protect pulse is armed when `we_n` falls with `hv_a9`=1, `hv_oe`=1 and `hv_ce`=0. If `we_n` stays low for at least PROT_US*CLK_PER_US clock edges, the rising `we_n` sets bit `sec_addr` (A18:A16) of `inhibit` and no other bit, and `op_done` is high for the next cycle.
- R3: A protect pulse that stays low for fewer clock edges than PROT_US*CLK_PER_US leaves `inhibit` unchanged and raises `pulse_error` for one cycle after the rising `we_n`.
- R4: An unprotect pulse is armed when `we_n` falls with `hv_a9`, `hv_oe` and `hv_ce` all 1, and with `addr_b6`, `addr_b12` and `sec_addr[0]` (A16) all 1. If all eight sectors are protected and `we_n` stays low for at least UNPROT_US*CLK_PER_US edges, the rising `we_n` clears `inhibit` to 00h and `op_done` pulses.
- R5: An armed unprotect with any bit of `inhibit` clear raises `unprot_reject` for the one cycle after the falling `we_n`. It starts no pulse, leaves `inhibit` unchanged and gives no `pulse_error` at the rising `we_n`.
- R6: An unprotect pulse shorter than UNPROT_US*CLK_PER_US edges leaves `inhibit` unchanged and raises `pulse_error` for one cycle.
- R7: A `we_n` pulse with no arm condition is ignored. This covers `hv_a9` low, and an unprotect whose `addr_b6`, `addr_b12` or A16 key bit is low. It raises no flag and does not change `inhibit`.
- R8: When a clock edge samples `ce_n`=0, `oe_n`=0, `we_n`=1, `hv_a9`=1 and `hv_oe`=0, then in the next cycle `rd_valid`=1 and `rd_data` is 01h if sector `sec_addr` is protected and 00h otherwise. Otherwise `rd_valid`=0 and `rd_data`=00h.
- R9: In the same cycle, `pe_go` = `pe_req` AND NOT `inhibit[pe_sector]`, and `pe_blocked` = `pe_req` AND `inhibit[pe_sector]`.
- R10: `busy` is high from the cycle after an armed falling `we_n` until the rising `we_n` is sampled. At most one of `op_done`, `pulse_error` and `unprot_reject` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we_n | input | 1 | Synchronized write strobe, active low |
| ce_n | input | 1 | Synchronized chip enable, active low |
| oe_n | input | 1 | Synchronized output enable, active low |
| hv_a9 | input | 1 | High-voltage qualifier present on address pin 9 |
| hv_oe | input | 1 | High-voltage qualifier present on output-enable pin |
| hv_ce | input | 1 | High-voltage qualifier present on chip-enable pin |
| sec_addr | input | 3 | Address bits 18:16, sector select |
| addr_b6 | input | 1 | Address bit 6 |
| addr_b12 | input | 1 | Address bit 12 |
| pe_req | input | 1 | Program/erase request |
| pe_sector | input | 3 | Sector targeted by the program/erase request |
| pe_go | output | 1 | Request may proceed |
| pe_blocked | output | 1 | Request ignored, sector protected |
| inhibit | output | 8 | Per-sector protection state |
| busy | output | 1 | A protect or unprotect pulse is being timed |
| op_done | output | 1 | One-cycle pulse, change committed |
| pulse_error | output | 1 | One-cycle pulse, write pulse too short |
| unprot_reject | output | 1 | One-cycle pulse, unprotect refused |
| rd_valid | output | 1 | Verify byte valid |
| rd_data | output | 8 | Verify byte |

## Verification
A wrong protection bit shows up at `inhibit` and `pe_go` in the cycle after the faulty commit. A verify read of that sector exposes it one cycle after the read is sampled. If the pulse counter drifts by even one cycle, the result at the exact limit flips between commit and `pulse_error`, so the bench holds pulses of exactly the minimum length and of one edge less. If the all-protected gate is wrong, `unprot_reject` either fires or stays silent in the cycle after the falling strobe. A wrongly taken unprotect then empties `inhibit` about ten thousand cycles later.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam int unsigned NUM_SEC = 8;
  localparam int unsigned SEC_W   = $clog2(NUM_SEC);

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_PROT   = 2'd1,
    OP_UNPROT = 2'd2
  } op_e;

  // Minimum number of low clock edges for a pulse of the given length.
  function automatic int unsigned min_low_cycles(input int unsigned us,
                                                 input int unsigned clk_per_us);
    return us * clk_per_us;
  endfunction

  // Address key that must be high for an unprotect to be armed.
  function automatic logic unprot_key(input logic b6, input logic b12, input logic b16);
    return b6 & b12 & b16;
  endfunction

  // Byte returned by a verify read for one sector's state.
  function automatic logic [7:0] verify_byte(input logic is_prot);
    return {7'b0, is_prot};
  endfunction
endpackage

// File: rtl/swp_arm_decode.sv
module swp_arm_decode
  import swp_pkg::*;
(
  input  logic hv_a9,
  input  logic hv_oe,
  input  logic hv_ce,
  input  logic key_b6,
  input  logic key_b12,
  input  logic key_b16,
  output logic arm_prot,
  output logic arm_unprot
);
  logic hv_pair;

  always_comb begin
    hv_pair    = hv_a9 & hv_oe;
    arm_prot   = hv_pair & ~hv_ce;
    arm_unprot = hv_pair & hv_ce & unprot_key(key_b6, key_b12, key_b16);
  end
endmodule

// File: rtl/swp_pulse_timer.sv
module swp_pulse_timer
  import swp_pkg::*;
#(
  parameter int unsigned PROT_MIN   = 100,
  parameter int unsigned UNPROT_MIN = 10000,
  parameter int unsigned SW         = 3,
  localparam int unsigned CNT_W     = $clog2(UNPROT_MIN + 1) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_n,
  input  logic          start_prot,
  input  logic          start_unprot,
  input  logic [SW-1:0] sector_in,
  output logic          busy,
  output logic          commit_prot,
  output logic          commit_unprot,
  output logic          short_pulse,
  output logic [SW-1:0] sector_q
);
  localparam logic [CNT_W-1:0] PROT_LIM   = CNT_W'(PROT_MIN);
  localparam logic [CNT_W-1:0] UNPROT_LIM = CNT_W'(UNPROT_MIN);

  op_e              state;
  logic [CNT_W-1:0] low_cnt;
  logic             rising;
  logic             long_enough;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= OP_IDLE;
      low_cnt  <= '0;
      sector_q <= '0;
    end else begin
      case (state)
        OP_IDLE: begin
          if (start_prot) begin
            state    <= OP_PROT;
            low_cnt  <= CNT_W'(1);
            sector_q <= sector_in;
          end else if (start_unprot) begin
            state    <= OP_UNPROT;
            low_cnt  <= CNT_W'(1);
            sector_q <= sector_in;
          end
        end
        OP_PROT, OP_UNPROT: begin
          if (we_n) begin
            state   <= OP_IDLE;
            low_cnt <= '0;
          end else if (low_cnt != '1) begin
            low_cnt <= low_cnt + 1'b1;
          end
        end
        default: state <= OP_IDLE;
      endcase
    end
  end

  always_comb begin
    busy          = (state != OP_IDLE);
    rising        = busy & we_n;
    long_enough   = (state == OP_UNPROT) ? (low_cnt >= UNPROT_LIM) : (low_cnt >= PROT_LIM);
    commit_prot   = rising & (state == OP_PROT) & long_enough;
    commit_unprot = rising & (state == OP_UNPROT) & long_enough;
    short_pulse   = rising & ~long_enough;
  end
endmodule

// File: rtl/swp_prot_store.sv
module swp_prot_store #(
  parameter int unsigned NSEC = 8,
  parameter int unsigned SW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [SW-1:0]   set_sec,
  input  logic            clr_all,
  output logic [NSEC-1:0] prot,
  output logic            all_set
);
  for (genvar i = 0; i < NSEC; i++) begin : g_sec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  prot[i] <= 1'b0;
      else if (clr_all)                            prot[i] <= 1'b0;
      else if (set_en && (set_sec == SW'(i)))      prot[i] <= 1'b1;
    end
  end

  assign all_set = &prot;
endmodule

// File: rtl/sector_wp_ctrl.sv
module sector_wp_ctrl
  import swp_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 50,
  parameter int unsigned PROT_US    = 100,
  parameter int unsigned UNPROT_US  = 10000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_n,
  input  logic               ce_n,
  input  logic               oe_n,
  input  logic               hv_a9,
  input  logic               hv_oe,
  input  logic               hv_ce,
  input  logic [SEC_W-1:0]   sec_addr,
  input  logic               addr_b6,
  input  logic               addr_b12,
  input  logic               pe_req,
  input  logic [SEC_W-1:0]   pe_sector,
  output logic               pe_go,
  output logic               pe_blocked,
  output logic [NUM_SEC-1:0] inhibit,
  output logic               busy,
  output logic               op_done,
  output logic               pulse_error,
  output logic               unprot_reject,
  output logic               rd_valid,
  output logic [7:0]         rd_data
);
  localparam int unsigned PROT_MIN   = min_low_cycles(PROT_US, CLK_PER_US);
  localparam int unsigned UNPROT_MIN = min_low_cycles(UNPROT_US, CLK_PER_US);

  // Named internal events
  logic we_q;
  logic we_fall;
  logic arm_prot;
  logic arm_unprot;
  logic all_set;
  logic start_prot;
  logic start_unprot;
  logic reject_now;
  logic commit_prot;
  logic commit_unprot;
  logic short_pulse;
  logic rd_cond;
  logic [SEC_W-1:0] sector_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  assign we_fall = we_q & ~we_n;

  swp_arm_decode u_arm (
    .hv_a9      (hv_a9),
    .hv_oe      (hv_oe),
    .hv_ce      (hv_ce),
    .key_b6     (addr_b6),
    .key_b12    (addr_b12),
    .key_b16    (sec_addr[0]),
    .arm_prot   (arm_prot),
    .arm_unprot (arm_unprot)
  );

  always_comb begin
    start_prot   = we_fall & ~busy & arm_prot;
    start_unprot = we_fall & ~busy & arm_unprot & all_set;
    reject_now   = we_fall & ~busy & arm_unprot & ~all_set;
  end

  swp_pulse_timer #(
    .PROT_MIN   (PROT_MIN),
    .UNPROT_MIN (UNPROT_MIN),
    .SW         (SEC_W)
  ) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .we_n          (we_n),
    .start_prot    (start_prot),
    .start_unprot  (start_unprot),
    .sector_in     (sec_addr),
    .busy          (busy),
    .commit_prot   (commit_prot),
    .commit_unprot (commit_unprot),
    .short_pulse   (short_pulse),
    .sector_q      (sector_q)
  );

  swp_prot_store #(
    .NSEC (NUM_SEC),
    .SW   (SEC_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (commit_prot),
    .set_sec (sector_q),
    .clr_all (commit_unprot),
    .prot    (inhibit),
    .all_set (all_set)
  );

  // Outcome flags, one cycle each
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_done       <= 1'b0;
      pulse_error   <= 1'b0;
      unprot_reject <= 1'b0;
    end else begin
      op_done       <= commit_prot | commit_unprot;
      pulse_error   <= short_pulse;
      unprot_reject <= reject_now;
    end
  end

  // Verify read path
  assign rd_cond = ~ce_n & ~oe_n & we_n & hv_a9 & ~hv_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= rd_cond;
      rd_data  <= rd_cond ? verify_byte(inhibit[sec_addr]) : 8'h00;
    end
  end

  // Program/erase gate
  always_comb begin
    pe_blocked = pe_req & inhibit[pe_sector];
    pe_go      = pe_req & ~inhibit[pe_sector];
  end
endmodule

// File: rtl/swp_checker.sv
module swp_checker #(
  parameter int unsigned NSEC = 8,
  parameter int unsigned SW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSEC-1:0] inhibit,
  input logic            op_done,
  input logic            pulse_error,
  input logic            unprot_reject,
  input logic            busy,
  input logic            pe_req,
  input logic            pe_go,
  input logic            pe_blocked,
  input logic [SW-1:0]   pe_sector,
  input logic            rd_valid,
  input logic [7:0]      rd_data
);
  assert_set_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit != $past(inhibit) && inhibit != '0) |->
      ((($past(inhibit) & ~inhibit) == '0) && $countones(inhibit ^ $past(inhibit)) == 1));

  assert_change_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit != $past(inhibit)) |-> op_done);

  assert_error_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_error |-> $stable(inhibit));

  assert_clear_from_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit == '0 && $past(inhibit) != '0) |-> ($past(inhibit) == '1));

  assert_reject_partial_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unprot_reject |-> (($past(inhibit) != '1) && !busy));

  assert_rd_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid ? (rd_data[7:1] == 7'd0) : (rd_data == 8'h00));

  assert_pe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pe_go |-> (!inhibit[pe_sector] && !pe_blocked && pe_req));

  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_done, pulse_error, unprot_reject}));
endmodule

bind sector_wp_ctrl swp_checker #(
  .NSEC (swp_pkg::NUM_SEC),
  .SW   (swp_pkg::SEC_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .inhibit       (inhibit),
  .op_done       (op_done),
  .pulse_error   (pulse_error),
  .unprot_reject (unprot_reject),
  .busy          (busy),
  .pe_req        (pe_req),
  .pe_go         (pe_go),
  .pe_blocked    (pe_blocked),
  .pe_sector     (pe_sector),
  .rd_valid      (rd_valid),
  .rd_data       (rd_data)
);

// File: tb/sector_wp_ctrl_test.sv
module sector_wp_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 1;
  localparam int PMIN       = 100 * CPU;
  localparam int UMIN       = 10000 * CPU;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1;
  logic hv_a9 = 1'b0, hv_oe = 1'b0, hv_ce = 1'b0;
  logic [2:0] sec_addr = '0;
  logic addr_b6 = 1'b0, addr_b12 = 1'b0;
  logic pe_req = 1'b0;
  logic [2:0] pe_sector = '0;
  logic pe_go, pe_blocked, busy, op_done, pulse_error, unprot_reject, rd_valid;
  logic [7:0] inhibit;
  logic [7:0] rd_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [7:0] exp_prot = 8'h00;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sector_wp_ctrl #(.CLK_PER_US(CPU)) uut (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .oe_n(oe_n),
    .hv_a9(hv_a9), .hv_oe(hv_oe), .hv_ce(hv_ce), .sec_addr(sec_addr),
    .addr_b6(addr_b6), .addr_b12(addr_b12), .pe_req(pe_req), .pe_sector(pe_sector),
    .pe_go(pe_go), .pe_blocked(pe_blocked), .inhibit(inhibit), .busy(busy),
    .op_done(op_done), .pulse_error(pulse_error), .unprot_reject(unprot_reject),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_verify(input logic [7:0] p, input logic [2:0] s);
    return {7'b0, p[s]};
  endfunction

  // Issue one write pulse and compare its outcome with the bench model.
  task automatic run_pulse(input string req, input logic a9v, input logic oev, input logic cev,
                           input logic [2:0] sec, input logic b6, input logic b12, input int low);
    logic prot_arm, unp_arm, exp_rej, started, met, exp_err, exp_done;
    logic rej, bsy, err, done;
    prot_arm = a9v & oev & ~cev;
    unp_arm  = a9v & oev & cev & b6 & b12 & sec[0];
    exp_rej  = unp_arm & (exp_prot != 8'hFF);
    started  = prot_arm | (unp_arm & ~exp_rej);
    met      = (low >= (prot_arm ? PMIN : UMIN));
    exp_err  = started & ~met;
    exp_done = started & met;
    @(negedge clk);
    hv_a9 = a9v; hv_oe = oev; hv_ce = cev;
    sec_addr = sec; addr_b6 = b6; addr_b12 = b12;
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    we_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rej = unprot_reject;
    bsy = busy;
    repeat (low - 1) @(posedge clk);
    @(negedge clk);
    we_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    err  = pulse_error;
    done = op_done;
    if (exp_done) exp_prot = prot_arm ? (exp_prot | (8'h01 << sec)) : 8'h00;
    chk({req, " reject flag"}, {31'b0, rej}, {31'b0, exp_rej});
    chk({"R10 busy during pulse (", req, ")"}, {31'b0, bsy}, {31'b0, started});
    chk({req, " pulse_error"}, {31'b0, err}, {31'b0, exp_err});
    chk({req, " op_done"}, {31'b0, done}, {31'b0, exp_done});
    chk({req, " inhibit"}, {24'b0, inhibit}, {24'b0, exp_prot});
    hv_a9 = 1'b0; hv_oe = 1'b0; hv_ce = 1'b0;
  endtask

  task automatic verify_read(input logic [2:0] sec, input logic b6);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    hv_a9 = 1'b1; hv_oe = 1'b0; hv_ce = 1'b0;
    sec_addr = sec; addr_b6 = b6;
    @(posedge clk);
    @(negedge clk);
    chk("R8 verify rd_valid", {31'b0, rd_valid}, 32'd1);
    chk("R8 verify rd_data", {24'b0, rd_data}, {24'b0, exp_verify(exp_prot, sec)});
    ce_n = 1'b1; oe_n = 1'b1; hv_a9 = 1'b0;
  endtask

  task automatic pe_check(input logic [2:0] s);
    @(negedge clk);
    pe_req = 1'b1; pe_sector = s;
    #1;
    chk("R9 pe_go", {31'b0, pe_go}, {31'b0, ~exp_prot[s]});
    chk("R9 pe_blocked", {31'b0, pe_blocked}, {31'b0, exp_prot[s]});
    pe_req = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 inhibit", {24'b0, inhibit}, 32'h0);
    chk("R1 flags", {27'b0, busy, op_done, pulse_error, unprot_reject, rd_valid}, 32'h0);
    chk("R1 rd_data", {24'b0, rd_data}, 32'h0);

    pe_check(3'd5);
    // R5: unprotect attempt with nothing protected
    run_pulse("R5", 1'b1, 1'b1, 1'b1, 3'd1, 1'b1, 1'b1, 20);
    // R7: no high-voltage qualifier on address 9
    run_pulse("R7", 1'b0, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0, PMIN + 5);

    // Constrained random protect pulses
    for (int i = 0; i < 30; i++) begin
      logic [2:0] s;
      int len;
      s = 3'($urandom % 8);
      if ($urandom % 4 == 0) len = PMIN - 1 - int'($urandom % 5);
      else                   len = PMIN + int'($urandom % 20);
      if (len < PMIN) run_pulse("R3", 1'b1, 1'b1, 1'b0, s, 1'($urandom), 1'($urandom), len);
      else            run_pulse("R2", 1'b1, 1'b1, 1'b0, s, 1'($urandom), 1'($urandom), len);
      verify_read(3'($urandom % 8), 1'($urandom));
      pe_check(3'($urandom % 8));
    end

    // R3: one edge short of the limit, then R2 exactly at it
    run_pulse("R3", 1'b1, 1'b1, 1'b0, 3'd6, 1'b0, 1'b0, PMIN - 1);
    for (int s = 0; s < 8; s++)
      if (!exp_prot[s]) run_pulse("R2", 1'b1, 1'b1, 1'b0, 3'(s), 1'b0, 1'b0, PMIN);
    chk("R2 all sectors protected", {24'b0, inhibit}, 32'hFF);

    // R7: unprotect key incomplete (address bit 12 low)
    run_pulse("R7", 1'b1, 1'b1, 1'b1, 3'd7, 1'b1, 1'b0, UMIN);
    // R6: unprotect one edge short
    run_pulse("R6", 1'b1, 1'b1, 1'b1, 3'd1, 1'b1, 1'b1, UMIN - 1);
    // R4: unprotect exactly at the limit
    run_pulse("R4", 1'b1, 1'b1, 1'b1, 3'd3, 1'b1, 1'b1, UMIN);
    for (int s = 0; s < 8; s++) verify_read(3'(s), 1'b1);
    pe_check(3'd0);

    // R8: a read without the verify qualifier returns nothing
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; hv_a9 = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R8 plain read rd_valid", {31'b0, rd_valid}, 32'd0);
    chk("R8 plain read rd_data", {24'b0, rd_data}, 32'd0);
    ce_n = 1'b1; oe_n = 1'b1;

    summary();
    $finish;
  end
endmodule